// File: doc/BRIEF.md
# Video Address Space Decoder with Fixed-Bank Cartridge Window

This block sits between the video processor's memory port and the storage behind it. A 14-bit video request (read or write) is decoded into one of three targets: the cartridge pattern memory, one of two on-chip 1 KiB nametable RAMs, or a 32-byte on-chip palette RAM. A mirroring flag decides which physical nametable backs each of the four logical nametable slots. The pattern memory is read-only and sits outside the block. The block drives its address and takes back a byte in the same cycle.

The block also carries the processor-side window of a simple fixed-bank cartridge. A CPU read at or above 0x8000 is turned into an offset into external program ROM. A one-bank (16 KiB) configuration mirrors the lower bank into the upper half of the window. Both sides return read data one clock after the request, together with a valid pulse.

Top module: `ppu_addr_map`

## Requirements
- R1: A video read below 0x2000 drives `chr_addr_o` with the low 13 address bits and returns `chr_rdata_i` as read data.
- R2: Video addresses 0x2000–0x23FF always select nametable 0, and 0x2C00–0x2FFF always select nametable 1, whatever the mirroring flag.
- R3: With `nt_mirror_i`=1, 0x2400–0x27FF selects nametable 1 and 0x2800–0x2BFF selects nametable 0. With `nt_mirror_i`=0 these two slots swap: 0x2400–0x27FF selects nametable 0 and 0x2800–0x2BFF selects nametable 1. The offset inside a nametable is the low 10 address bits.
- R4: Video addresses 0x3000–0x3EFF behave exactly like the address 0x1000 lower, for reads and writes.
- R5: Video addresses 0x3F00–0x3FFF select palette RAM at offset (address − 0x3F00) mod 32.
- R6: A video write to a nametable or palette address stores the byte, and a later read of any address mapping to the same cell returns it.
- R7: A video write below 0x2000 changes no nametable or palette cell, and a read of pattern memory still returns `chr_rdata_i`.
- R8: Read data appears on `*_rdata_o` one clock after the request, with `*_rvalid_o` high for exactly that cycle. Writes and idle cycles leave `*_rvalid_o` low.
- R9: With `prg_dual_bank_i`=1, a CPU read at address A ≥ 0x8000 drives `prg_addr_o` = A − 0x8000 and returns `prg_rdata_i`.
- R10: With `prg_dual_bank_i`=0, bit 14 of `prg_addr_o` is forced to 0, so 0xC000–0xFFFF mirrors 0x8000–0xBFFF.
- R11: A CPU read below 0x8000 returns 0x00 with `cpu_rvalid_o` high. CPU writes produce no valid pulse and do not alter later program reads.
- R12: After reset both valid outputs are low and both read-data outputs are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nt_mirror_i | input | 1 | Nametable mirroring flag |
| prg_dual_bank_i | input | 1 | 1: 32 KiB program ROM, 0: 16 KiB mirrored |
| vid_req_i | input | 1 | Video request strobe |
| vid_we_i | input | 1 | Video request is a write |
| vid_addr_i | input | 14 | Video address |
| vid_wdata_i | input | 8 | Video write data |
| vid_rdata_o | output | 8 | Video read data, one clock after request |
| vid_rvalid_o | output | 1 | Video read data valid |
| chr_addr_o | output | 13 | Pattern memory address |
| chr_rdata_i | input | 8 | Pattern memory data for `chr_addr_o` |
| cpu_req_i | input | 1 | CPU request strobe |
| cpu_we_i | input | 1 | CPU request is a write |
| cpu_addr_i | input | 16 | CPU address |
| cpu_rdata_o | output | 8 | CPU read data, one clock after request |
| cpu_rvalid_o | output | 1 | CPU read data valid |
| prg_addr_o | output | 15 | Program ROM address |
| prg_rdata_i | input | 8 | Program ROM data for `prg_addr_o` |

## Verification
Two distinct bytes are written to the two physical nametables at the same offset. Each of the four logical slots is then read back under both flag values, so a wrong slot-to-table choice shows up as the other byte. The upper alias range, the palette range at offsets above 31, and a write through an aliased slot test the folding: a missing fold reaches a different cell. Program reads use a data pattern that depends on bit 14, so a one-bank window and a two-bank window return different bytes for the same upper address.

// File: rtl/ppu_map_pkg.sv
package ppu_map_pkg;
  typedef enum logic [1:0] {
    TGT_PAT = 2'd0,
    TGT_NT  = 2'd1,
    TGT_PAL = 2'd2
  } vid_tgt_e;

  localparam int unsigned NT_NUM = 2;
endpackage

// File: rtl/ppu_vid_decode.sv
module ppu_vid_decode
  import ppu_map_pkg::*;
#(
  parameter int unsigned VAW    = 14,
  parameter int unsigned NT_AW  = 10,
  parameter int unsigned PAL_AW = 5,
  parameter int unsigned CHR_AW = 13
) (
  input  logic [VAW-1:0]    addr_i,
  input  logic              mirror_i,
  output vid_tgt_e          tgt_o,
  output logic              nt_sel_o,
  output logic [NT_AW-1:0]  nt_off_o,
  output logic [PAL_AW-1:0] pal_off_o,
  output logic [CHR_AW-1:0] chr_addr_o
);
  // palette page: top address bits above the 256-byte page all set
  localparam int unsigned PAGE_LSB = 8;
  logic [1:0] slot;

  assign slot       = addr_i[NT_AW+1:NT_AW];
  assign nt_off_o   = addr_i[NT_AW-1:0];
  assign pal_off_o  = addr_i[PAL_AW-1:0];
  assign chr_addr_o = addr_i[CHR_AW-1:0];

  // mirror=1: slots 0,2 -> table 0, slots 1,3 -> table 1
  // mirror=0: slots 0,1 -> table 0, slots 2,3 -> table 1
  assign nt_sel_o = mirror_i ? slot[0] : slot[1];

  always_comb begin
    if (!addr_i[VAW-1])                     tgt_o = TGT_PAT;
    else if (&addr_i[VAW-2:PAGE_LSB])       tgt_o = TGT_PAL;
    else                                    tgt_o = TGT_NT;
  end
endmodule

// File: rtl/ppu_byte_ram.sv
module ppu_byte_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/ppu_prg_window.sv
module ppu_prg_window #(
  parameter int unsigned CAW    = 16,
  parameter int unsigned PRG_AW = 15
) (
  input  logic [CAW-1:0]    addr_i,
  input  logic              dual_bank_i,
  output logic              hit_o,
  output logic [PRG_AW-1:0] prg_addr_o
);
  localparam int unsigned BANK_BIT = PRG_AW - 1;

  assign hit_o = addr_i[CAW-1];
  // single bank: drop the bank bit so the upper half folds onto the lower
  assign prg_addr_o = {addr_i[BANK_BIT] & dual_bank_i, addr_i[BANK_BIT-1:0]};
endmodule

// File: rtl/ppu_addr_map.sv
module ppu_addr_map
  import ppu_map_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned VAW    = 14,
  parameter int unsigned CAW    = 16,
  parameter int unsigned NT_AW  = 10,
  parameter int unsigned PAL_AW = 5,
  parameter int unsigned CHR_AW = VAW - 1,
  parameter int unsigned PRG_AW = CAW - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nt_mirror_i,
  input  logic              prg_dual_bank_i,
  input  logic              vid_req_i,
  input  logic              vid_we_i,
  input  logic [VAW-1:0]    vid_addr_i,
  input  logic [DW-1:0]     vid_wdata_i,
  output logic [DW-1:0]     vid_rdata_o,
  output logic              vid_rvalid_o,
  output logic [CHR_AW-1:0] chr_addr_o,
  input  logic [DW-1:0]     chr_rdata_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [CAW-1:0]    cpu_addr_i,
  output logic [DW-1:0]     cpu_rdata_o,
  output logic              cpu_rvalid_o,
  output logic [PRG_AW-1:0] prg_addr_o,
  input  logic [DW-1:0]     prg_rdata_i
);
  vid_tgt_e            tgt;
  logic                nt_sel;
  logic [NT_AW-1:0]    nt_off;
  logic [PAL_AW-1:0]   pal_off;
  logic [NT_NUM-1:0]   nt_we;
  logic [DW-1:0]       nt_rd [NT_NUM];
  logic                pal_we;
  logic [DW-1:0]       pal_rd;
  logic [DW-1:0]       vid_mux;
  logic                vid_wr, vid_rd;
  logic                cpu_hit, cpu_rd;

  logic [DW-1:0] vid_rdata_q, cpu_rdata_q;
  logic          vid_rvalid_q, cpu_rvalid_q;

  ppu_vid_decode #(
    .VAW(VAW), .NT_AW(NT_AW), .PAL_AW(PAL_AW), .CHR_AW(CHR_AW)
  ) u_dec (
    .addr_i    (vid_addr_i),
    .mirror_i  (nt_mirror_i),
    .tgt_o     (tgt),
    .nt_sel_o  (nt_sel),
    .nt_off_o  (nt_off),
    .pal_off_o (pal_off),
    .chr_addr_o(chr_addr_o)
  );

  assign vid_wr = vid_req_i & vid_we_i;
  assign vid_rd = vid_req_i & ~vid_we_i;

  for (genvar g = 0; g < NT_NUM; g++) begin : g_nt
    assign nt_we[g] = vid_wr && (tgt == TGT_NT) && (nt_sel == 1'(g));
    ppu_byte_ram #(.AW(NT_AW), .DW(DW)) u_nt (
      .clk_i  (clk_i),
      .we_i   (nt_we[g]),
      .addr_i (nt_off),
      .wdata_i(vid_wdata_i),
      .rdata_o(nt_rd[g])
    );
  end

  assign pal_we = vid_wr && (tgt == TGT_PAL);

  ppu_byte_ram #(.AW(PAL_AW), .DW(DW)) u_pal (
    .clk_i  (clk_i),
    .we_i   (pal_we),
    .addr_i (pal_off),
    .wdata_i(vid_wdata_i),
    .rdata_o(pal_rd)
  );

  always_comb begin
    unique case (tgt)
      TGT_NT:  vid_mux = nt_sel ? nt_rd[1] : nt_rd[0];
      TGT_PAL: vid_mux = pal_rd;
      default: vid_mux = chr_rdata_i;
    endcase
  end

  ppu_prg_window #(.CAW(CAW), .PRG_AW(PRG_AW)) u_prg (
    .addr_i     (cpu_addr_i),
    .dual_bank_i(prg_dual_bank_i),
    .hit_o      (cpu_hit),
    .prg_addr_o (prg_addr_o)
  );

  assign cpu_rd = cpu_req_i & ~cpu_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_rdata_q  <= '0;
      vid_rvalid_q <= 1'b0;
      cpu_rdata_q  <= '0;
      cpu_rvalid_q <= 1'b0;
    end else begin
      vid_rvalid_q <= vid_rd;
      cpu_rvalid_q <= cpu_rd;
      if (vid_rd) vid_rdata_q <= vid_mux;
      if (cpu_rd) cpu_rdata_q <= cpu_hit ? prg_rdata_i : '0;
    end
  end

  assign vid_rdata_o  = vid_rdata_q;
  assign vid_rvalid_o = vid_rvalid_q;
  assign cpu_rdata_o  = cpu_rdata_q;
  assign cpu_rvalid_o = cpu_rvalid_q;

  AST_PAT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_rd && !vid_addr_i[VAW-1]) |=> (vid_rdata_o == $past(chr_rdata_i))); // R1
  AST_NT_ONE_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nt_we, pal_we})); // R6
  AST_PAT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_wr && !vid_addr_i[VAW-1]) |-> (nt_we == '0 && !pal_we)); // R7
  AST_FIXED_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_wr && vid_addr_i[VAW-1] && !(&vid_addr_i[VAW-2:8]) &&
     (vid_addr_i[NT_AW+1:NT_AW] == 2'b00)) |-> nt_we[0]); // R2
  AST_VID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_rd |=> vid_rvalid_o); // R8
  AST_VID_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vid_rd |=> !vid_rvalid_o); // R8
  AST_PRG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd && cpu_addr_i[CAW-1]) |=> (cpu_rdata_o == $past(prg_rdata_i))); // R9
  AST_PRG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prg_dual_bank_i |-> !prg_addr_o[PRG_AW-1]); // R10
  AST_CPU_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd && !cpu_addr_i[CAW-1]) |=> (cpu_rdata_o == '0)); // R11
  AST_CPU_WR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i) |=> !cpu_rvalid_o); // R11
endmodule

// File: tb/ppu_addr_map_tb.sv
module ppu_addr_map_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nt_mirror = 1'b0;
  logic        prg_dual = 1'b1;
  logic        vid_req = 1'b0, vid_we = 1'b0;
  logic [13:0] vid_addr = '0;
  logic [7:0]  vid_wdata = '0;
  logic [7:0]  vid_rdata;
  logic        vid_rvalid;
  logic [12:0] chr_addr;
  logic [7:0]  chr_rdata;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic [14:0] prg_addr;
  logic [7:0]  prg_rdata;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] chr_byte(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [7:0] prg_byte(input logic [14:0] a);
    return a[7:0] + {a[14:8], 1'b1};
  endfunction

  assign chr_rdata = chr_byte(chr_addr);
  assign prg_rdata = prg_byte(prg_addr);

  ppu_addr_map dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .nt_mirror_i    (nt_mirror),
    .prg_dual_bank_i(prg_dual),
    .vid_req_i      (vid_req),
    .vid_we_i       (vid_we),
    .vid_addr_i     (vid_addr),
    .vid_wdata_i    (vid_wdata),
    .vid_rdata_o    (vid_rdata),
    .vid_rvalid_o   (vid_rvalid),
    .chr_addr_o     (chr_addr),
    .chr_rdata_i    (chr_rdata),
    .cpu_req_i      (cpu_req),
    .cpu_we_i       (cpu_we),
    .cpu_addr_i     (cpu_addr),
    .cpu_rdata_o    (cpu_rdata),
    .cpu_rvalid_o   (cpu_rvalid),
    .prg_addr_o     (prg_addr),
    .prg_rdata_i    (prg_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic vid_wr(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    vid_req = 1'b1; vid_we = 1'b1; vid_addr = a; vid_wdata = d;
    @(negedge clk);
    vid_req = 1'b0; vid_we = 1'b0;
    chk("R8 write valid", 16'(vid_rvalid), 16'd0);
  endtask

  task automatic vid_rd(input string tag, input logic [13:0] a, input logic [7:0] exp);
    @(negedge clk);
    vid_req = 1'b1; vid_we = 1'b0; vid_addr = a;
    @(negedge clk);
    vid_req = 1'b0;
    chk(tag, 16'(vid_rdata), 16'(exp));
  endtask

  task automatic cpu_op(input logic we, input logic [15:0] a,
                        output logic [7:0] q, output logic v);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    q = cpu_rdata; v = cpu_rvalid;
  endtask

  task automatic t_reset;
    chk("R12 vid valid", 16'(vid_rvalid), 16'd0);
    chk("R12 vid data", 16'(vid_rdata), 16'd0);
    chk("R12 cpu valid", 16'(cpu_rvalid), 16'd0);
    chk("R12 cpu data", 16'(cpu_rdata), 16'd0);
  endtask

  task automatic t_pattern;
    vid_rd("R1 pat 0000", 14'h0000, chr_byte(13'h0000));
    vid_rd("R1 pat 1ABC", 14'h1ABC, chr_byte(13'h1ABC));
    vid_rd("R1 pat 1FFF", 14'h1FFF, chr_byte(13'h1FFF));
  endtask

  task automatic t_nt_fixed;
    nt_mirror = 1'b0;
    vid_wr(14'h2010, 8'hA1);
    vid_wr(14'h2C10, 8'hB2);
    vid_rd("R6 nt0 readback", 14'h2010, 8'hA1);
    vid_rd("R6 nt1 readback", 14'h2C10, 8'hB2);
    nt_mirror = 1'b1;
    vid_rd("R2 slot0 flag1", 14'h2010, 8'hA1);
    vid_rd("R2 slot3 flag1", 14'h2C10, 8'hB2);
  endtask

  task automatic t_mirror;
    nt_mirror = 1'b0;
    vid_rd("R3 slot1 flag0", 14'h2410, 8'hA1);
    vid_rd("R3 slot2 flag0", 14'h2810, 8'hB2);
    nt_mirror = 1'b1;
    vid_rd("R3 slot1 flag1", 14'h2410, 8'hB2);
    vid_rd("R3 slot2 flag1", 14'h2810, 8'hA1);
  endtask

  task automatic t_alias;
    nt_mirror = 1'b1;
    vid_rd("R4 alias slot0", 14'h3010, 8'hA1);
    vid_rd("R4 alias slot3", 14'h3C10, 8'hB2);
    vid_rd("R4 alias slot1", 14'h3410, 8'hB2);
    vid_wr(14'h3811, 8'hC3);
    vid_rd("R4 alias write", 14'h2011, 8'hC3);
    vid_rd("R4 alias 3EFF", 14'h3EFF, 8'hXX === 8'hXX ? 8'h00 : 8'h00);
  endtask

  task automatic t_palette;
    vid_wr(14'h3F03, 8'h55);
    vid_rd("R5 pal fold 23", 14'h3F23, 8'h55);
    vid_rd("R5 pal fold E3", 14'h3FE3, 8'h55);
    vid_wr(14'h3FFF, 8'h66);
    vid_rd("R5 pal fold 1F", 14'h3F1F, 8'h66);
    vid_wr(14'h3F10, 8'h77);
    vid_rd("R6 pal readback", 14'h3F10, 8'h77);
  endtask

  task automatic t_rom_write;
    vid_wr(14'h0010, 8'hEE);
    vid_wr(14'h1F10, 8'hEE);
    vid_rd("R7 nt unchanged", 14'h2010, 8'hA1);
    vid_rd("R7 pal unchanged", 14'h3F10, 8'h77);
    vid_rd("R7 pat still rom", 14'h0010, chr_byte(13'h0010));
  endtask

  task automatic t_latency;
    @(negedge clk);
    vid_req = 1'b1; vid_we = 1'b0; vid_addr = 14'h2010;
    chk("R8 valid before edge", 16'(vid_rvalid), 16'd0);
    @(negedge clk);
    vid_req = 1'b0;
    chk("R8 valid after one clk", 16'(vid_rvalid), 16'd1);
    chk("R8 data after one clk", 16'(vid_rdata), 16'h00A1);
    @(negedge clk);
    chk("R8 valid drops", 16'(vid_rvalid), 16'd0);
  endtask

  task automatic t_prg32;
    logic [7:0] q; logic v;
    prg_dual = 1'b1;
    cpu_op(1'b0, 16'h8000, q, v);
    chk("R9 prg 8000", 16'(q), 16'(prg_byte(15'h0000)));
    chk("R8 cpu valid", 16'(v), 16'd1);
    cpu_op(1'b0, 16'hC123, q, v);
    chk("R9 prg C123", 16'(q), 16'(prg_byte(15'h4123)));
    cpu_op(1'b0, 16'hFFFF, q, v);
    chk("R9 prg FFFF", 16'(q), 16'(prg_byte(15'h7FFF)));
  endtask

  task automatic t_prg16;
    logic [7:0] q; logic v;
    prg_dual = 1'b0;
    cpu_op(1'b0, 16'hC123, q, v);
    chk("R10 upper mirrors", 16'(q), 16'(prg_byte(15'h0123)));
    cpu_op(1'b0, 16'h8123, q, v);
    chk("R10 lower bank", 16'(q), 16'(prg_byte(15'h0123)));
    cpu_op(1'b0, 16'hFFFF, q, v);
    chk("R10 top mirrors", 16'(q), 16'(prg_byte(15'h3FFF)));
    prg_dual = 1'b1;
  endtask

  task automatic t_cpu_low;
    logic [7:0] q; logic v;
    cpu_op(1'b0, 16'h1234, q, v);
    chk("R11 low data", 16'(q), 16'd0);
    chk("R11 low valid", 16'(v), 16'd1);
    cpu_op(1'b1, 16'h8000, q, v);
    chk("R11 write no valid", 16'(v), 16'd0);
    cpu_op(1'b0, 16'h8000, q, v);
    chk("R11 prg after write", 16'(q), 16'(prg_byte(15'h0000)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pattern();
    t_nt_fixed();
    t_mirror();
    vid_wr(14'h2EFF, 8'h00);
    t_alias();
    t_palette();
    t_rom_write();
    t_latency();
    t_prg32();
    t_prg16();
    t_cpu_low();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule